// File: doc/BRIEF.md
# Flash completion polling controller

This block sits on the host side of a parallel flash bus. On a start request it writes the unlock-and-command write sequence for a program, a sector erase or a whole-chip erase. It then reads status from the device until the operation has finished, and reports pass or fail to the requester. Each status read happens at the target address.

Two ways of detecting completion are supported, and a mode input chosen at start selects between them. In the first, the controller compares the top status bit with the true value it expects. In the second, it reads status twice and checks whether the toggle bit has stopped changing. In both, the timeout bit does not cause an immediate failure. The completion bits can change in the same read as the timeout bit, so the controller repeats the status check once before it declares a failure. After a timeout failure it writes a reset command, which returns the device to array reads.

Every bus cycle has a fixed active width. After each cycle comes a minimum number of idle clocks. Both counts are parameters, so write pulse width and recovery times are met without analogue timing logic.

Top module: `fpoll_ctrl`

## Requirements
- R1: While reset is low and after it is released, fl_ce_n, fl_we_n and fl_oe_n are high, and req_done and req_err are low.
- R2: The command writes, as (address, data), are: program (555h,AAh),(2AAh,55h),(555h,A0h),(target,data). Sector erase is (555h,AAh),(2AAh,55h),(555h,80h),(555h,AAh),(2AAh,55h),(target,30h). Chip erase is the same as sector erase but ends with (555h,10h). req_op is 0 for program, 1 for sector erase and 2 for chip erase; 3 acts as program.
- R3: Every bus cycle holds fl_ce_n low with exactly one of fl_we_n (write) or fl_oe_n (read) low for ACT_CLKS clocks. At least GAP_CLKS clocks with all three strobes high follow each cycle.
- R4: With req_mode=0, each status read is judged on its own. The operation is complete when bit 7 equals bit 7 of the expected value. The expected value is the program data, or FFh for either erase.
- R5: With req_mode=0, a read that is not complete but has bit 5 set causes exactly one more read. If that read is complete, the verify step decides the result; otherwise the operation fails.
- R6: With req_mode=1, status is read in pairs. The operation is complete when bit 6 is equal in both reads, and the second read is the value that is verified.
- R7: With req_mode=1, a toggling pair whose second read has bit 5 set causes one more pair. If that pair still toggles, the operation fails.
- R8: On a timeout failure (R5 or R7), the controller writes F0h to the target address before done.
- R9: On completion, req_err is set if the verified read differs from the expected value. No reset write is issued in this case.
- R10: req_done is high for exactly one clock. req_err is valid in the same clock as req_done, stays held until the next accepted start, and is low in the clock after that start.
- R11: req_start has no effect while an operation is in progress.
- R12: Every status read, including those for chip erase, is issued at the address supplied with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_op | input | 2 | Operation code (R2) |
| req_addr | input | AW | Target address; polling address |
| req_data | input | DW | Program data |
| req_mode | input | 1 | 0: data-bit polling, 1: toggle-bit polling |
| req_start | input | 1 | Start request, sampled when idle |
| req_done | output | 1 | One-clock completion pulse |
| req_err | output | 1 | Operation failed; held until next start |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The main corner case is a status read that shows the timeout bit while the operation is still busy, with the very next read showing the operation complete. A controller that fails on the first timeout bit would report an error there, and one that never rechecks would poll forever on a hung device.

A device model that never finishes checks three things in each polling mode: the single recheck, the failure, and the F0h reset write. A device that completes with one wrong data bit checks that verification is separate from completion. A controller that trusted bit 7 alone would report a pass.

Stray start pulses in the middle of an operation would show up as unexpected command writes. Gaps between bus cycles are measured on every clock.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
   typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SERASE = 2'd1, OP_CERASE = 2'd2} fop_e;
   typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_RDA, ST_RDB, ST_RST, ST_DONE} fst_e;

   localparam int BIT_POLL = 7;
   localparam int BIT_TGL  = 6;
   localparam int BIT_TMO  = 5;
   localparam int STEP_W   = 3;

   localparam logic [11:0] UNLK_A  = 12'h555;
   localparam logic [11:0] UNLK_B  = 12'h2AA;
   localparam logic [7:0]  C_KEY1  = 8'hAA;
   localparam logic [7:0]  C_KEY2  = 8'h55;
   localparam logic [7:0]  C_PROG  = 8'hA0;
   localparam logic [7:0]  C_ERS   = 8'h80;
   localparam logic [7:0]  C_SECT  = 8'h30;
   localparam logic [7:0]  C_CHIP  = 8'h10;
   localparam logic [7:0]  C_RESET = 8'hF0;
endpackage

// File: rtl/fpoll_cmdrom.sv
module fpoll_cmdrom
   import fpoll_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  fop_e              op,
   input  logic [STEP_W-1:0] step,
   input  logic [AW-1:0]     tgt,
   input  logic [DW-1:0]     pdata,
   output logic [AW-1:0]     addr,
   output logic [DW-1:0]     data,
   output logic              last
);
   logic erase, chip;
   assign erase = (op == OP_SERASE) || (op == OP_CERASE);
   assign chip  = (op == OP_CERASE);

   always_comb begin
      addr = AW'(UNLK_A);
      data = DW'(C_KEY1);
      last = 1'b0;
      case (step)
         3'd0: ;
         3'd1: begin addr = AW'(UNLK_B); data = DW'(C_KEY2); end
         3'd2: data = erase ? DW'(C_ERS) : DW'(C_PROG);
         3'd3: begin
            if (!erase) begin
               addr = tgt;
               data = pdata;
               last = 1'b1;
            end
         end
         3'd4: begin addr = AW'(UNLK_B); data = DW'(C_KEY2); end
         default: begin
            last = 1'b1;
            if (chip) data = DW'(C_CHIP);
            else begin
               addr = tgt;
               data = DW'(C_SECT);
            end
         end
      endcase
   end
endmodule

// File: rtl/fpoll_buscyc.sv
module fpoll_buscyc #(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int ACT_CLKS = 2,
   parameter int GAP_CLKS = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          fin,
   output logic [DW-1:0] rdata,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_wdata,
   input  logic [DW-1:0] fl_rdata,
   output logic          fl_ce_n,
   output logic          fl_we_n,
   output logic          fl_oe_n
);
   localparam int TOT = ACT_CLKS + GAP_CLKS;
   localparam int CW  = $clog2(TOT + 1);
   localparam logic [CW-1:0] C_ACT  = CW'(ACT_CLKS);
   localparam logic [CW-1:0] C_SAMP = CW'(ACT_CLKS - 1);
   localparam logic [CW-1:0] C_LAST = CW'(TOT - 1);

   logic          run_q, wr_q, strobe;
   logic [CW-1:0] cnt_q;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q, rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         wr_q  <= 1'b0;
         cnt_q <= '0;
         a_q   <= '0;
         d_q   <= '0;
         rd_q  <= '0;
      end else if (!run_q) begin
         if (go) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            wr_q  <= wr;
            a_q   <= addr;
            d_q   <= wdata;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == C_SAMP && !wr_q) rd_q <= fl_rdata;
         if (cnt_q == C_LAST) run_q <= 1'b0;
      end
   end

   assign strobe   = run_q && (cnt_q < C_ACT);
   assign fin      = run_q && (cnt_q == C_LAST);
   assign rdata    = rd_q;
   assign fl_addr  = a_q;
   assign fl_wdata = d_q;
   assign fl_ce_n  = ~strobe;
   assign fl_we_n  = ~(strobe && wr_q);
   assign fl_oe_n  = ~(strobe && !wr_q);
endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge
   import fpoll_pkg::*;
#(
   parameter int DW        = 8,
   parameter int TOGGLE_EN = 1
) (
   input  logic          tgl_mode,
   input  logic [DW-1:0] ra,
   input  logic [DW-1:0] rb,
   input  logic [DW-1:0] expv,
   output logic          complete,
   output logic          tmo,
   output logic          bad
);
   logic data_done;
   assign data_done = (rb[BIT_POLL] == expv[BIT_POLL]);
   assign tmo       = rb[BIT_TMO];
   assign bad       = (rb != expv);

   generate
      if (TOGGLE_EN != 0) begin : g_both
         assign complete = tgl_mode ? (ra[BIT_TGL] == rb[BIT_TGL]) : data_done;
      end else begin : g_data_only
         logic unused_in;
         assign unused_in = tgl_mode ^ (^ra);
         assign complete  = data_done;
      end
   endgenerate
endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
   import fpoll_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int ACT_CLKS  = 2,
   parameter int GAP_CLKS  = 3,
   parameter int TOGGLE_EN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic          req_mode,
   input  logic          req_start,
   output logic          req_done,
   output logic          req_err,
   output logic [AW-1:0] fl_addr,
   output logic [DW-1:0] fl_wdata,
   input  logic [DW-1:0] fl_rdata,
   output logic          fl_ce_n,
   output logic          fl_we_n,
   output logic          fl_oe_n
);
   initial begin
      assert (DW >= 8)       else $error("DW must hold the status bits");
      assert (AW >= 12)      else $error("AW must hold the unlock addresses");
      assert (ACT_CLKS >= 1) else $error("ACT_CLKS must be at least 1");
      assert (GAP_CLKS >= 1) else $error("GAP_CLKS must be at least 1");
   end

   fst_e              st;
   fop_e              op_q;
   logic [AW-1:0]     tgt_q;
   logic [DW-1:0]     dat_q, ra_q, expv;
   logic [STEP_W-1:0] step_q;
   logic              tgl_q, rechk_q, err_q;

   logic          b_go, b_wr, b_fin;
   logic [AW-1:0] b_addr, rom_addr;
   logic [DW-1:0] b_wdata, b_rdata, rom_data;
   logic          rom_last, j_cmp, j_tmo, j_bad, eval;

   assign expv = (op_q == OP_SERASE || op_q == OP_CERASE) ? '1 : dat_q;

   fpoll_cmdrom #(.AW(AW), .DW(DW)) u_rom (
      .op(op_q), .step(step_q), .tgt(tgt_q), .pdata(dat_q),
      .addr(rom_addr), .data(rom_data), .last(rom_last));

   fpoll_judge #(.DW(DW), .TOGGLE_EN(TOGGLE_EN)) u_judge (
      .tgl_mode(tgl_q), .ra(ra_q), .rb(b_rdata), .expv(expv),
      .complete(j_cmp), .tmo(j_tmo), .bad(j_bad));

   always_comb begin
      b_go    = (st == ST_CMD) || (st == ST_RDA) || (st == ST_RDB) || (st == ST_RST);
      b_wr    = (st != ST_RDA) && (st != ST_RDB);
      b_addr  = (st == ST_CMD) ? rom_addr : tgt_q;
      b_wdata = (st == ST_CMD) ? rom_data : DW'(C_RESET);
   end

   fpoll_buscyc #(.AW(AW), .DW(DW), .ACT_CLKS(ACT_CLKS), .GAP_CLKS(GAP_CLKS)) u_bus (
      .clk(clk), .rst_n(rst_n), .go(b_go), .wr(b_wr), .addr(b_addr), .wdata(b_wdata),
      .fin(b_fin), .rdata(b_rdata), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

   assign eval = b_fin && ((st == ST_RDA && !tgl_q) || st == ST_RDB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         op_q    <= OP_PROG;
         tgt_q   <= '0;
         dat_q   <= '0;
         ra_q    <= '0;
         step_q  <= '0;
         tgl_q   <= 1'b0;
         rechk_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (req_start) begin
               op_q    <= fop_e'(req_op);
               tgt_q   <= req_addr;
               dat_q   <= req_data;
               tgl_q   <= req_mode && (TOGGLE_EN != 0);
               step_q  <= '0;
               rechk_q <= 1'b0;
               err_q   <= 1'b0;
               st      <= ST_CMD;
            end
            ST_CMD: if (b_fin) begin
               if (rom_last) st <= ST_RDA;
               else step_q <= step_q + 1'b1;
            end
            ST_RDA: if (b_fin) begin
               ra_q <= b_rdata;
               if (tgl_q) st <= ST_RDB;
            end
            ST_RST: if (b_fin) begin
               err_q <= 1'b1;
               st    <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: ;
         endcase
         if (eval) begin
            if (j_cmp) begin
               err_q <= j_bad;
               st    <= ST_DONE;
            end else if (rechk_q) begin
               st <= ST_RST;
            end else begin
               if (j_tmo) rechk_q <= 1'b1;
               st <= ST_RDA;
            end
         end
      end
   end

   assign req_done = (st == ST_DONE);
   assign req_err  = err_q;
endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
   parameter int ACT_CLKS = 2,
   parameter int GAP_CLKS = 3
) (
   input logic clk,
   input logic rst_n,
   input logic fl_ce_n,
   input logic fl_we_n,
   input logic fl_oe_n,
   input logic req_start,
   input logic req_done,
   input logic req_err
);
   localparam logic [7:0] ACT8 = 8'(ACT_CLKS);
   localparam logic [7:0] GAP8 = 8'(GAP_CLKS);

   logic [7:0] lo_cnt, hi_cnt;
   logic       seen_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt  <= '0;
         hi_cnt  <= '0;
         seen_lo <= 1'b0;
      end else begin
         lo_cnt <= fl_ce_n ? 8'd0 : lo_cnt + 8'd1;
         if (!fl_ce_n) begin
            hi_cnt  <= '0;
            seen_lo <= 1'b1;
         end else if (hi_cnt != 8'hFF) begin
            hi_cnt <= hi_cnt + 8'd1;
         end
      end
   end

   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n && !fl_oe_n));
   p_strobe_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
   p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_ce_n) |-> (lo_cnt == ACT8));
   p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(fl_ce_n) && seen_lo) |-> (hi_cnt >= GAP8));
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> !req_done);
   p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_err && !req_start) |=> req_err);
   p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_err) |-> req_done);
   p_done_bus_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |-> fl_ce_n);
endmodule

bind fpoll_ctrl fpoll_chk #(.ACT_CLKS(ACT_CLKS), .GAP_CLKS(GAP_CLKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
   .req_start(req_start), .req_done(req_done), .req_err(req_err));

// File: tb/tb_fpoll_ctrl.sv
module tb_fpoll_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 16;
   localparam int DW  = 8;
   localparam int ACT = 2;
   localparam int GAP = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          req_mode = 1'b0;
   logic          req_start = 1'b0;
   logic          req_done, req_err;
   logic [AW-1:0] fl_addr;
   logic [DW-1:0] fl_wdata, fl_rdata;
   logic          fl_ce_n, fl_we_n, fl_oe_n;

   fpoll_ctrl #(.AW(AW), .DW(DW), .ACT_CLKS(ACT), .GAP_CLKS(GAP), .TOGGLE_EN(1)) dut (
      .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .req_mode(req_mode), .req_start(req_start), .req_done(req_done), .req_err(req_err),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
      .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   int n_done = 0;
   int n_ops = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural flash device and expected write queue
   logic [AW-1:0] q_a[$];
   logic [DW-1:0] q_d[$];
   int            seq_len = 0, nwr = 0, k = 0, m_nbusy = 0, m_toat = 0;
   bit            m_active = 0, m_hang = 0;
   logic [DW-1:0] m_exp = '0, m_flip = '0;
   logic [AW-1:0] m_tgt = '0;

   always_comb begin
      if (m_active && (m_hang || k < m_nbusy)) begin
         fl_rdata    = '0;
         fl_rdata[7] = ~m_exp[7];
         fl_rdata[6] = k[0];
         fl_rdata[5] = (k >= m_toat);
      end else begin
         fl_rdata = m_exp ^ m_flip;
      end
   end

   logic          pw = 1'b1, po = 1'b1, pc = 1'b1;
   logic [AW-1:0] la = '0;
   logic [DW-1:0] ld = '0;
   int            lo = 0, hi = 0;
   bit            seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!fl_we_n) begin la = fl_addr; ld = fl_wdata; end
         if (!fl_oe_n) la = fl_addr;
         if (!fl_ce_n)
            chk((fl_we_n ^ fl_oe_n) == 1'b1, "R3", "one strobe per cycle", {fl_we_n, fl_oe_n}, 1);
         else
            chk(fl_we_n && fl_oe_n, "R3", "strobe outside ce", {fl_we_n, fl_oe_n}, 3);
         if (fl_ce_n && !pc) chk(lo == ACT, "R3", "active width", lo, ACT);
         if (!fl_ce_n && pc && seen) chk(hi >= GAP, "R3", "idle gap", hi, GAP);
         if (fl_we_n && !pw) begin
            if (q_a.size() == 0) begin
               chk(0, "R2", "unexpected write", {la, ld}, 0);
            end else begin
               chk(la == q_a[0] && ld == q_d[0], "R2", "write addr/data", {la, ld}, {q_a[0], q_d[0]});
               void'(q_a.pop_front());
               void'(q_d.pop_front());
            end
            nwr++;
            if (nwr > seq_len && ld == 8'hF0) m_active = 0;
            else if (nwr == seq_len) begin m_active = 1; k = 0; end
         end
         if (fl_oe_n && !po) begin
            chk(la == m_tgt, "R12", "poll address", la, m_tgt);
            if (m_active) k++;
         end
         if (!fl_ce_n) begin lo++; hi = 0; seen = 1; end
         else begin lo = 0; hi++; end
         if (req_done) n_done++;
         pw = fl_we_n; po = fl_oe_n; pc = fl_ce_n;
      end
   end

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit mode, input int nb, input int ta, input bit hang,
                         input logic [DW-1:0] flip, input bit poke, input string req);
      logic [DW-1:0] ev;
      bit            exp_err;
      int            cyc;
      ev = (op == 2'd1 || op == 2'd2) ? 8'hFF : d;
      exp_err = hang || (flip != 0);
      m_exp = ev; m_flip = flip; m_hang = hang; m_nbusy = nb; m_toat = ta; m_tgt = a;
      nwr = 0; m_active = 0; k = 0;
      q_a.push_back(16'h555); q_d.push_back(8'hAA);
      q_a.push_back(16'h2AA); q_d.push_back(8'h55);
      if (op == 2'd1 || op == 2'd2) begin
         q_a.push_back(16'h555); q_d.push_back(8'h80);
         q_a.push_back(16'h555); q_d.push_back(8'hAA);
         q_a.push_back(16'h2AA); q_d.push_back(8'h55);
         if (op == 2'd2) begin q_a.push_back(16'h555); q_d.push_back(8'h10); end
         else begin q_a.push_back(a); q_d.push_back(8'h30); end
      end else begin
         q_a.push_back(16'h555); q_d.push_back(8'hA0);
         q_a.push_back(a); q_d.push_back(d);
      end
      seq_len = q_a.size();
      if (hang) begin q_a.push_back(a); q_d.push_back(8'hF0); end
      n_ops++;
      @(negedge clk);
      req_op = op; req_addr = a; req_data = d; req_mode = mode; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      chk(req_err == 1'b0, "R10", "err cleared after start", req_err, 0);
      cyc = 0;
      while (!req_done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
         if (poke && cyc == 7) begin
            req_start = 1'b1; req_op = 2'd2; req_addr = 16'hBEEF; req_mode = ~mode;
         end else if (poke && cyc == 8) begin
            req_start = 1'b0;
         end
         if (poke && cyc == 40) begin
            req_start = 1'b1; req_op = 2'd1; req_addr = 16'h0BAD;
         end else if (poke && cyc == 41) begin
            req_start = 1'b0;
         end
      end
      if (!req_done) begin
         chk(0, "R10", "done never seen", 0, 1);
         return;
      end
      chk(req_err == exp_err, req, "err at done", req_err, exp_err);
      chk(q_a.size() == 0, hang ? "R8" : "R2", "writes left at done", q_a.size(), 0);
      @(negedge clk);
      chk(req_done == 1'b0, "R10", "done one clock", req_done, 0);
      chk(req_err == exp_err, "R10", "err held after done", req_err, exp_err);
      repeat (4) @(negedge clk);
      chk(req_err == exp_err, "R10", "err held while idle", req_err, exp_err);
      q_a.delete(); q_d.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
      chk(!req_done && !req_err, "R1", "status in reset", {req_done, req_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes after reset", {fl_ce_n, fl_we_n, fl_oe_n}, 7);
      chk(!req_done && !req_err, "R1", "status after reset", {req_done, req_err}, 0);
      // R4 program, data polling
      run_op(2'd0, 16'h0100, 8'hA5, 1'b0, 3, 99, 0, 8'h00, 0, "R4");
      // R6 program, toggle polling
      run_op(2'd0, 16'h0200, 8'h3C, 1'b1, 4, 99, 0, 8'h00, 0, "R6");
      // R4 sector erase, data polling, FFh expected
      run_op(2'd1, 16'h8000, 8'h00, 1'b0, 5, 99, 0, 8'h00, 0, "R4");
      // R12 chip erase, toggle polling, polled at supplied address
      run_op(2'd2, 16'h1234, 8'h00, 1'b1, 3, 99, 0, 8'h00, 0, "R12");
      // R5 timeout bit with completion on the recheck read: pass
      run_op(2'd0, 16'h0300, 8'h42, 1'b0, 3, 2, 0, 8'h00, 0, "R5");
      // R5 R8 hung device, data polling: fail plus reset write
      run_op(2'd0, 16'h0400, 8'h11, 1'b0, 3, 2, 1, 8'h00, 0, "R5");
      // R7 timeout on a toggling pair, next pair stable: pass
      run_op(2'd0, 16'h0500, 8'h5A, 1'b1, 6, 5, 0, 8'h00, 0, "R7");
      // R7 R8 hung device, toggle polling: fail plus reset write
      run_op(2'd1, 16'hA000, 8'h00, 1'b1, 3, 3, 1, 8'h00, 0, "R7");
      // R9 completes with a wrong data bit: fail, no reset write
      run_op(2'd0, 16'h0600, 8'h81, 1'b0, 3, 99, 0, 8'h01, 0, "R9");
      // R9 erase verify in toggle mode with a wrong bit
      run_op(2'd1, 16'hC000, 8'h00, 1'b1, 2, 99, 0, 8'h04, 0, "R9");
      // R11 start pulses in mid-operation are ignored
      run_op(2'd0, 16'h2222, 8'h77, 1'b0, 4, 99, 0, 8'h00, 1, "R11");
      chk(n_done == n_ops, "R11", "done pulse count", n_done, n_ops);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", n_done, n_ops);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule